// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 raw interrupt lines and presents them to a processor as two active-low request lines: a normal request and a fast request. Each source has a mode register and a handler-address register. The mode register holds a 3-bit priority, where 7 is the most urgent, and a 2-bit trigger type. The trigger type sets level or edge sensitivity and the polarity. Source 0 is reserved for the fast request and never competes on the normal line. The other sources compete for the normal line by priority.

Software works the block through a plain register bus with single-cycle read and write strobes. Read data is registered. It appears in the cycle after the read strobe and holds until the next read. Reading the normal vector address returns the handler address of the winning source. That read also acknowledges the source: the source becomes the one in service, and an edge-latched request is consumed. The normal line then stays quiet until software writes end-of-interrupt for that source. When no source can win, the read returns a programmable spurious address. Software issues enable, disable, set, clear and end-of-interrupt commands as one-hot source bitmaps written to their own command addresses.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, nirq and nfiq are high, every mask bit is 0, the read data is 0 and no source is in service.
- R2: The mode word of source i is at byte offset 4*i. Its bits 2:0 hold the priority and bits 6:5 hold the trigger type, and it reads back in those same positions.
- R3: A trigger type of 00 makes a source pending while its input is low, and 10 while its input is high. The input is sampled once, so pending follows the pin one cycle later. Set and clear commands have no effect on such a source.
- R4: A trigger type of 11 latches pending on a rising input and 01 on a falling one. A bitmap written to 0x12C sets edge latches and one written to 0x128 clears them. When a set and a clear reach the same latch in the same cycle, the set wins.
- R5: A bitmap written to 0x120 enables sources and one written to 0x124 disables them. The mask reads at 0x110, and a disabled source does not drive either request line.
- R6: nirq is low exactly when some source numbered 1 or above is both pending and enabled, and no source is in service.
- R7: Among the competing sources, the highest priority wins. On equal priority, the lower source number wins.
- R8: A read of 0x100 with a winner present returns that source's handler word, held at 0x80+4*i. The same read records the source number in bits 4:0 of the status word at 0x108, marks the source in service and clears its edge latch. The pending bitmap reads at 0x10C.
- R9: A read of 0x100 with no winner, or with a source already in service, returns the spurious word held at 0x134 and changes no state.
- R10: While a source is in service, nirq stays high. Writing 0x130 with the bit of the in-service source set retires it. A bitmap that lacks that bit is ignored.
- R11: nfiq is low exactly when source 0 is pending and enabled. A read of 0x104 then returns the handler word of source 0 and clears its edge latch; with source 0 inactive, the read returns the spurious word. Source 0 never affects nirq.
- R12: The core status word at 0x114 reports an active fast request in bit 0 and an active normal request in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data or command bitmap |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after bus_rd |
| src_in | input | NUM_SRC | Raw interrupt lines |
| nirq | output | 1 | Normal interrupt request, active low |
| nfiq | output | 1 | Fast interrupt request, active low |

## Verification
The bench builds the block with NUM_SRC set to 8 and a 32-bit vector width. At that size every source slot carries its own priority, trigger type and handler word. This brings all four trigger encodings, a three-way priority contest with a tie and the fast source into one short run. A behavioural model follows the same bus and pin activity and predicts nirq, nfiq and every read result on each clock. Directed checks cover the acknowledge, spurious and retire sequences.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'b00,
    TRIG_EDGE_FALL = 2'b01,
    TRIG_LVL_HIGH  = 2'b10,
    TRIG_EDGE_RISE = 2'b11
  } trig_e;

  localparam int PRIO_W = 3;

  localparam logic [11:0] OFS_IVR  = 12'h100;
  localparam logic [11:0] OFS_FVR  = 12'h104;
  localparam logic [11:0] OFS_STAT = 12'h108;
  localparam logic [11:0] OFS_PEND = 12'h10C;
  localparam logic [11:0] OFS_MASK = 12'h110;
  localparam logic [11:0] OFS_CORE = 12'h114;
  localparam logic [11:0] OFS_EN   = 12'h120;
  localparam logic [11:0] OFS_DIS  = 12'h124;
  localparam logic [11:0] OFS_CLR  = 12'h128;
  localparam logic [11:0] OFS_SET  = 12'h12C;
  localparam logic [11:0] OFS_EOI  = 12'h130;
  localparam logic [11:0] OFS_SPUR = 12'h134;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell
  import vic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  raw,
  input  trig_e trig,
  input  logic  set_cmd,
  input  logic  clr_cmd,
  input  logic  ack,
  output logic  pend
);
  logic raw_q;
  logic latch_q;
  logic hit;
  logic lvl;

  always_comb begin
    hit  = (trig == TRIG_EDGE_RISE) ? (raw & ~raw_q) : (~raw & raw_q);
    lvl  = (trig == TRIG_LVL_HIGH) ? raw_q : ~raw_q;
    pend = trig[0] ? latch_q : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      raw_q   <= raw;
      latch_q <= trig[0] ? ((latch_q & ~clr_cmd & ~ack) | hit | set_cmd) : 1'b0;
    end
  end
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      found,
  output logic [IDX_W-1:0]          win_id
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found  = 1'b0;
    win_id = '0;
    best   = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
        found  = 1'b1;
        win_id = IDX_W'(i);
        best   = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               nirq,
  output logic               nfiq
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [PRIO_W-1:0]         prio_q [NUM_SRC];
  trig_e                     trig_q [NUM_SRC];
  logic [VEC_W-1:0]          vec_q  [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [VEC_W-1:0]          spur_q;
  logic [NUM_SRC-1:0]        mask_q;
  logic                      busy_q;
  logic [IDX_W-1:0]          cur_q;
  logic [DATA_W-1:0]         rdata_q;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] wmap;
  logic [NUM_SRC-1:0] set_vec, clr_vec, ack_vec;
  logic               found;
  logic [IDX_W-1:0]   win_id;
  logic [4:0]         slot;
  logic               in_smr, in_svr;
  logic               hit_ivr, hit_fvr, hit_stat, hit_pend, hit_mask, hit_core;
  logic               hit_en, hit_dis, hit_clr, hit_set, hit_eoi, hit_spur;
  logic               irq_act, fiq_act, irq_grant, fiq_grant;
  logic [DATA_W-1:0]  rd_mux;

  // Address decode
  assign slot     = bus_addr[6:2];
  assign in_smr   = (bus_addr[ADDR_W-1:7] == '0);
  assign in_svr   = (bus_addr[ADDR_W-1:7] == (ADDR_W-7)'(1));
  assign hit_ivr  = (bus_addr == ADDR_W'(OFS_IVR));
  assign hit_fvr  = (bus_addr == ADDR_W'(OFS_FVR));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_pend = (bus_addr == ADDR_W'(OFS_PEND));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_core = (bus_addr == ADDR_W'(OFS_CORE));
  assign hit_en   = (bus_addr == ADDR_W'(OFS_EN));
  assign hit_dis  = (bus_addr == ADDR_W'(OFS_DIS));
  assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));
  assign hit_set  = (bus_addr == ADDR_W'(OFS_SET));
  assign hit_eoi  = (bus_addr == ADDR_W'(OFS_EOI));
  assign hit_spur = (bus_addr == ADDR_W'(OFS_SPUR));

  assign wmap    = bus_wdata[NUM_SRC-1:0];
  assign set_vec = (bus_wr && hit_set) ? wmap : '0;
  assign clr_vec = (bus_wr && hit_clr) ? wmap : '0;

  // Per-source configuration and trigger logic
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
        trig_q[g] <= TRIG_LVL_LOW;
        vec_q[g]  <= '0;
      end else if (bus_wr && in_smr && slot == 5'(g)) begin
        prio_q[g] <= bus_wdata[PRIO_W-1:0];
        trig_q[g] <= trig_e'(bus_wdata[6:5]);
      end else if (bus_wr && in_svr && slot == 5'(g)) begin
        vec_q[g] <= bus_wdata[VEC_W-1:0];
      end
    end

    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];

    vic_src_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (src_in[g]),
      .trig    (trig_q[g]),
      .set_cmd (set_vec[g]),
      .clr_cmd (clr_vec[g]),
      .ack     (ack_vec[g]),
      .pend    (pend[g])
    );
  end

  // Arbitration over sources 1..NUM_SRC-1
  assign cand = pend & mask_q & ~NUM_SRC'(1);

  vic_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .cand      (cand),
    .prio_flat (prio_flat),
    .found     (found),
    .win_id    (win_id)
  );

  assign irq_act   = found & ~busy_q;
  assign fiq_act   = pend[0] & mask_q[0];
  assign irq_grant = bus_rd & hit_ivr & irq_act;
  assign fiq_grant = bus_rd & hit_fvr & fiq_act;
  assign ack_vec   = (irq_grant ? (NUM_SRC'(1) << win_id) : '0)
                   | (fiq_grant ? NUM_SRC'(1) : '0);

  assign nirq = ~irq_act;
  assign nfiq = ~fiq_act;

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    if (in_smr) begin
      if (32'(slot) < NUM_SRC)
        rd_mux = DATA_W'({trig_q[slot[IDX_W-1:0]], 2'b00, prio_q[slot[IDX_W-1:0]]});
    end else if (in_svr) begin
      if (32'(slot) < NUM_SRC)
        rd_mux = DATA_W'(vec_q[slot[IDX_W-1:0]]);
    end else if (hit_ivr) begin
      rd_mux = irq_act ? DATA_W'(vec_q[win_id]) : DATA_W'(spur_q);
    end else if (hit_fvr) begin
      rd_mux = fiq_act ? DATA_W'(vec_q[0]) : DATA_W'(spur_q);
    end else if (hit_stat) begin
      rd_mux = DATA_W'(cur_q);
    end else if (hit_pend) begin
      rd_mux = DATA_W'(pend);
    end else if (hit_mask) begin
      rd_mux = DATA_W'(mask_q);
    end else if (hit_core) begin
      rd_mux = DATA_W'({irq_act, fiq_act});
    end else if (hit_spur) begin
      rd_mux = DATA_W'(spur_q);
    end
  end

  // Global state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_q  <= '0;
      mask_q  <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      if (irq_grant) begin
        busy_q <= 1'b1;
        cur_q  <= win_id;
      end
      if (bus_wr) begin
        if (hit_en)   mask_q <= mask_q | wmap;
        if (hit_dis)  mask_q <= mask_q & ~wmap;
        if (hit_spur) spur_q <= bus_wdata[VEC_W-1:0];
        if (hit_eoi && busy_q && wmap[cur_q]) busy_q <= 1'b0;
      end
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               nirq,
  input logic               nfiq,
  input logic               busy,
  input logic [IDX_W-1:0]   cur,
  input logic [NUM_SRC-1:0] mask,
  input logic [VEC_W-1:0]   spur
);
  logic [NUM_SRC-1:0] wmap;
  logic is_ivr, is_en, is_eoi;
  assign wmap   = bus_wdata[NUM_SRC-1:0];
  assign is_ivr = (bus_addr == ADDR_W'(12'h100));
  assign is_en  = (bus_addr == ADDR_W'(12'h120));
  assign is_eoi = (bus_addr == ADDR_W'(12'h130));

  AST_BUSY_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> nirq); // R10
  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_ivr && !nirq) |=> busy); // R8
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_eoi && busy && wmap[cur]) |=> !busy); // R10
  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_ivr && nirq) |=> (bus_rdata == DATA_W'($past(spur)))); // R9
  AST_FIQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !nfiq |-> mask[0]); // R11
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_en) |=> ((mask & $past(wmap)) == $past(wmap))); // R5
endmodule

bind vec_irq_ctrl vic_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
) u_vic_checker (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nirq(nirq), .nfiq(nfiq),
  .busy(busy_q), .cur(cur_q), .mask(mask_q), .spur(spur_q)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] src = 8'hE8;
  logic        nirq, nfiq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit armed   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(9), .DATA_W(32), .VEC_W(32)) i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src), .nirq(nirq), .nfiq(nfiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_prio [N];
  int          m_trig [N];
  logic [31:0] m_vec  [N];
  bit          m_mask [N];
  bit          m_edge [N];
  bit          m_srcq [N];
  logic [31:0] m_spur, m_rdata;
  bit          m_busy, m_rd_seen;
  int          m_cur;

  function automatic bit m_pending(int i);
    if (m_trig[i] % 2 == 1) return m_edge[i];
    if (m_trig[i] == 2) return m_srcq[i];
    return !m_srcq[i];
  endfunction

  function automatic int m_winner();
    int best = -1;
    for (int i = 1; i < N; i++)
      if (m_pending(i) && m_mask[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
    return best;
  endfunction

  function automatic bit m_irq_on();
    return (m_winner() >= 0) && !m_busy;
  endfunction

  function automatic bit m_fiq_on();
    return m_pending(0) && m_mask[0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = 0;
        m_mask[i] = 0; m_edge[i] = 0; m_srcq[i] = 0;
      end
      m_spur = 0; m_rdata = 0; m_busy = 0; m_cur = 0; m_rd_seen = 0;
    end else begin
      int w;
      int slot;
      bit [N-1:0] setm, clrm, ackm;
      w = m_winner(); slot = int'(addr[6:2]);
      setm = '0; clrm = '0; ackm = '0;
      if (rd) begin
        m_rd_seen = 1;
        m_rdata = 0;
        if (addr[8:7] == 2'b00) begin
          if (slot < N) m_rdata = 32'((m_trig[slot] << 5) + m_prio[slot]);
        end else if (addr[8:7] == 2'b01) begin
          if (slot < N) m_rdata = m_vec[slot];
        end else if (addr == 9'h100) begin
          if (w >= 0 && !m_busy) begin
            m_rdata = m_vec[w]; ackm[w] = 1; m_busy = 1; m_cur = w;
          end else m_rdata = m_spur;
        end else if (addr == 9'h104) begin
          if (m_fiq_on()) begin m_rdata = m_vec[0]; ackm[0] = 1; end
          else m_rdata = m_spur;
        end else if (addr == 9'h108) m_rdata = 32'(m_cur);
        else if (addr == 9'h10C) begin
          for (int i = 0; i < N; i++) m_rdata[i] = m_pending(i);
        end else if (addr == 9'h110) begin
          for (int i = 0; i < N; i++) m_rdata[i] = m_mask[i];
        end else if (addr == 9'h114) begin
          m_rdata[0] = m_fiq_on();
          m_rdata[1] = (w >= 0) && (ackm == 0 ? !m_busy : 1'b1);
        end else if (addr == 9'h134) m_rdata = m_spur;
      end
      if (wr) begin
        if (addr == 9'h12C) setm = wdata[N-1:0];
        if (addr == 9'h128) clrm = wdata[N-1:0];
        if (addr == 9'h130 && m_busy && wdata[m_cur]) m_busy = 0;
        if (addr == 9'h134) m_spur = wdata;
        for (int i = 0; i < N; i++) begin
          if (addr == 9'h120 && wdata[i]) m_mask[i] = 1;
          if (addr == 9'h124 && wdata[i]) m_mask[i] = 0;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (m_trig[i] % 2 == 1) begin
          bit hit;
          hit = (m_trig[i] == 3) ? (src[i] && !m_srcq[i]) : (!src[i] && m_srcq[i]);
          m_edge[i] = (m_edge[i] && !clrm[i] && !ackm[i]) || hit || setm[i];
        end else m_edge[i] = 0;
      end
      if (wr && addr[8:7] == 2'b00 && slot < N) begin
        m_prio[slot] = int'(wdata[2:0]); m_trig[slot] = int'(wdata[6:5]);
      end
      if (wr && addr[8:7] == 2'b01 && slot < N) m_vec[slot] = wdata;
      for (int i = 0; i < N; i++) m_srcq[i] = src[i];
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && armed && !done) begin
      chk("R6 nirq vs model", 32'(nirq), 32'(!m_irq_on()));
      chk("R11 nfiq vs model", 32'(nfiq), 32'(!m_fiq_on()));
      if (m_rd_seen) begin
        chk("R8 rdata vs model", rdata, m_rdata);
        m_rd_seen = 0;
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
      finish_run();
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 nirq after reset", 32'(nirq), 32'd1);
    chk("R1 nfiq after reset", 32'(nfiq), 32'd1);
    chk("R1 rdata after reset", rdata, 32'd0);
    armed = 1;
    rd_reg(9'h110, d); chk("R1 mask after reset", d, 32'd0);

    // Configure: priority in 2:0, trigger in 6:5
    wr_reg(9'h000, 32'h67);  // src0 rising, prio 7
    wr_reg(9'h004, 32'h43);  // src1 high level, prio 3
    wr_reg(9'h008, 32'h65);  // src2 rising, prio 5
    wr_reg(9'h00C, 32'h25);  // src3 falling, prio 5
    wr_reg(9'h010, 32'h45);  // src4 high level, prio 5
    wr_reg(9'h014, 32'h02);  // src5 low level, prio 2
    for (int i = 0; i < N; i++) wr_reg(9'(9'h080 + 4*i), 32'h1000 + 32'(i*16));
    wr_reg(9'h134, 32'hDEAD);
    rd_reg(9'h008, d); chk("R2 mode word readback", d, 32'h65);
    rd_reg(9'h08C, d); chk("R8 handler word readback", d, 32'h1030);
    rd_reg(9'h10C, d); chk("R3 nothing pending at idle", d, 32'h0);
    wr_reg(9'h120, 32'hFF);
    rd_reg(9'h110, d); chk("R5 mask after enable", d, 32'hFF);

    // Level source then a higher-priority edge
    @(negedge clk); src[1] = 1'b1;
    idle(2); chk("R6 nirq low on level source", 32'(nirq), 32'd0);
    @(negedge clk); src[2] = 1'b1;
    idle(2);
    rd_reg(9'h100, d); chk("R7 higher priority wins", d, 32'h1020);
    rd_reg(9'h108, d); chk("R8 status holds number", d, 32'd2);
    chk("R10 nirq held while in service", 32'(nirq), 32'd1);
    rd_reg(9'h100, d); chk("R9 spurious while in service", d, 32'hDEAD);
    rd_reg(9'h10C, d); chk("R8 edge latch consumed", d, 32'h02);
    wr_reg(9'h130, 32'h04);
    idle(1); chk("R10 nirq back after retire", 32'(nirq), 32'd0);

    // Equal priority tie and a wrong retire bitmap
    @(negedge clk); src[3] = 1'b0; src[4] = 1'b1;
    idle(2);
    rd_reg(9'h100, d); chk("R7 tie goes to lower number", d, 32'h1030);
    wr_reg(9'h130, 32'h10);
    idle(1); chk("R10 foreign retire ignored", 32'(nirq), 32'd1);
    wr_reg(9'h130, 32'h08);
    rd_reg(9'h100, d); chk("R7 level tie partner next", d, 32'h1040);
    wr_reg(9'h130, 32'h10);
    @(negedge clk); src[4] = 1'b0; src[1] = 1'b0; src[3] = 1'b1;
    idle(2); chk("R6 nirq high when nothing pending", 32'(nirq), 32'd1);
    rd_reg(9'h10C, d); chk("R3 level pending follows pin", d, 32'h0);

    // Set and clear commands
    wr_reg(9'h12C, 32'h06);
    rd_reg(9'h10C, d); chk("R4 set hits edge only", d, 32'h04);
    wr_reg(9'h128, 32'h04);
    rd_reg(9'h10C, d); chk("R4 clear empties latch", d, 32'h0);

    // Disable and re-enable an active-low level source
    wr_reg(9'h124, 32'h20);
    @(negedge clk); src[5] = 1'b0;
    idle(2);
    rd_reg(9'h10C, d); chk("R3 low level pending", d, 32'h20);
    chk("R5 disabled source silent", 32'(nirq), 32'd1);
    rd_reg(9'h110, d); chk("R5 mask after disable", d, 32'hDF);
    wr_reg(9'h120, 32'h20);
    idle(1); chk("R5 re-enabled source drives", 32'(nirq), 32'd0);
    rd_reg(9'h100, d); chk("R8 low level vector", d, 32'h1050);
    wr_reg(9'h130, 32'h20);
    @(negedge clk); src[5] = 1'b1;
    idle(2);

    // Fast source
    @(negedge clk); src[0] = 1'b1;
    idle(2);
    chk("R11 nfiq low on source 0", 32'(nfiq), 32'd0);
    chk("R11 source 0 stays off nirq", 32'(nirq), 32'd1);
    rd_reg(9'h114, d); chk("R12 core status fast only", d, 32'h1);
    rd_reg(9'h104, d); chk("R11 fast vector", d, 32'h1000);
    chk("R11 nfiq released", 32'(nfiq), 32'd1);
    rd_reg(9'h104, d); chk("R11 fast read when idle", d, 32'hDEAD);

    wr_reg(9'h12C, 32'h04);
    rd_reg(9'h114, d); chk("R12 core status normal only", d, 32'h2);
    rd_reg(9'h100, d); chk("R8 vector after set command", d, 32'h1020);
    wr_reg(9'h130, 32'h04);
    idle(3);
    finish_run();
  end
endmodule